// File: doc/BRIEF.md
# Multi-CPU private window decoder

This block sits behind a 4 KB private peripheral window shared by up to four CPUs. Each request carries a 12-bit window offset and the ID of the CPU that issued it. The decoder sorts the offset into one of three regions: a small snoop-control register group that it implements itself, a set of interrupt-controller CPU interface windows, and a set of timer-pair windows. It then drives a one-hot select and a local offset towards the downstream interrupt-controller and timer blocks.

Two kinds of window exist for each downstream resource. An alias window always reaches the resources of the requesting CPU. A banked window picks the CPU from the address page. Inside a timer window, offset bit 5 chooses between the plain timer and the watchdog of the CPU's pair, and the decoder also reports the private interrupt number that the selected unit raises. A strap input gives the number of CPUs that are present. Accesses to an absent CPU are dropped quietly. Offsets outside every window raise an error flag.

Selects, local offset and write strobe are combinational in the request cycle. The response (valid, read data, error) is registered and appears one cycle later. Read data comes either from the local snoop-control registers or from the downstream read bus, which is sampled in the request cycle.

Top module: `priv_window_decoder`

## Requirements
- R1: The snoop-control enable register lives at offset 0x000. It resets to 0. Only bit 0 of a write is stored, and a read returns that bit in bit 0 with every other bit zero.
- R2: A read of offset 0x004 returns a configuration word. It holds a mask of present CPUs, one bit per CPU, in bits [7:4], and (CPU count − 1) in bits [1:0]. Example: 4 CPUs read as 0xF3 and 2 CPUs as 0x31.
- R3: Reads of offsets 0x008 and 0x00C return zero. A write to 0x00C is accepted without error and leaves the enable register unchanged.
- R4: A valid request at offsets 0x100–0x1FF asserts `intc_sel[req_cpu]`. `tgt_offset` carries offset bits [7:0].
- R5: Offsets 0x200–0x5FF assert `intc_sel[(offset − 0x200) >> 8]`, with offset bits [7:0] on `tgt_offset`.
- R6: Offsets 0x600–0x6FF reach the pair of the requesting CPU c. With offset bit 5 clear this is `timer_sel[2c]` and `tgt_irq_num` is 29. With bit 5 set it is `timer_sel[2c+1]` and `tgt_irq_num` is 30. `tgt_offset` carries offset bits [3:0] and its upper bits are zero.
- R7: Offsets 0x700–0xAFF reach the pair of CPU c = (offset − 0x700) >> 8, with the same bit-5, interrupt-number and offset rules as R6.
- R8: When the addressed CPU index is not below `cpu_count`, no select is raised, `tgt_write` stays low, a read returns zero and `rsp_err` stays low.
- R9: Offsets 0xB00–0xFFF, and snoop-control offsets other than 0x000, 0x004, 0x008 and 0x00C, set `rsp_err` for exactly the next cycle. Such a request raises no select, reads as zero and leaves the enable register unchanged.
- R10: `rsp_valid` is high exactly one cycle after each cycle with `req_valid` high. A routed read returns the `dn_rdata` value seen in the request cycle. Writes return zero read data. `tgt_write` is high only for a routed write, and `tgt_wdata` equals `req_wdata`.
- R11: While `rst_n` is low at a clock edge, the response outputs clear to zero and the enable register clears to 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_count | input | 3 | Number of CPUs present, 1 to 4 |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_cpu | input | 2 | ID of the requesting CPU |
| req_addr | input | 12 | Offset inside the private window |
| req_wdata | input | 32 | Write data |
| dn_rdata | input | 32 | Read data from the selected downstream unit, same cycle |
| intc_sel | output | 4 | One-hot interrupt-controller interface select, per CPU |
| timer_sel | output | 8 | One-hot timer select, index 2·cpu (timer) or 2·cpu+1 (watchdog) |
| tgt_offset | output | 8 | Local register offset for the selected unit |
| tgt_irq_num | output | 5 | Private interrupt number of the selected timer unit, else 0 |
| tgt_write | output | 1 | Write strobe for the selected unit |
| tgt_wdata | output | 32 | Write data towards downstream units |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | Registered error flag for an unmapped offset |

## Verification
The hardest case to reach is a banked page or alias that names a CPU which is absent. With four CPUs strapped, every banked page is valid and a 2-bit CPU ID is always in range. The stimulus therefore lowers `cpu_count` to 2 and then to 1 during the run. With the smaller count it aims banked pages and alias requests at the missing CPUs, and it rereads the configuration word to confirm the new mask. A second case is the enable register surviving stray writes. A nonzero value is stored first, then writes go to the invalidate and unmapped snoop offsets, and a read-back follows.

// File: rtl/priv_dec_pkg.sv
// Package: shared window map, window kinds and interrupt numbers for the
// private window decoder. Assumes a 4 KB window split into 256-byte pages.
package priv_dec_pkg;

    typedef enum logic [1:0] {
        WIN_NONE = 2'd0,
        WIN_SCU  = 2'd1,
        WIN_INTC = 2'd2,
        WIN_TMR  = 2'd3
    } win_e;

    // Page numbers (offset bits [11:8]) where each region starts
    localparam logic [3:0] PG_SCU        = 4'h0;
    localparam logic [3:0] PG_INTC_ALIAS = 4'h1;
    localparam logic [3:0] PG_INTC_BANK0 = 4'h2;
    localparam logic [3:0] PG_TMR_ALIAS  = 4'h6;
    localparam logic [3:0] PG_TMR_BANK0  = 4'h7;
    localparam logic [3:0] PG_END        = 4'hB;

    // Snoop-control register offsets
    localparam logic [7:0] SCU_CTL   = 8'h00;
    localparam logic [7:0] SCU_CFG   = 8'h04;
    localparam logic [7:0] SCU_STAT  = 8'h08;
    localparam logic [7:0] SCU_INVAL = 8'h0C;

    // Private interrupt numbers of a timer pair
    localparam logic [4:0] IRQ_TIMER = 5'd29;
    localparam logic [4:0] IRQ_WDOG  = 5'd30;

endpackage

// File: rtl/priv_addr_decode.sv
// Module: priv_addr_decode
// Sorts an offset page into a window kind and resolves the target CPU index.
// Alias pages use the requesting CPU, banked pages take it from the page.
// Assumes MAX_CPU <= 4 so that the banked regions hold one page per CPU.
module priv_addr_decode
    import priv_dec_pkg::*;
#(
    parameter int MAX_CPU = 4,
    parameter int CPU_W   = 2,
    parameter int CNT_W   = 3
) (
    input  logic [3:0]       page,
    input  logic [CPU_W-1:0] req_cpu,
    input  logic [CNT_W-1:0] cpu_count,
    output win_e             win,
    output logic [3:0]       cpu_idx,
    output logic             in_range,
    output logic             bad_page
);

    // Window kind and CPU index from the page number
    always_comb begin
        win      = WIN_NONE;
        cpu_idx  = '0;
        bad_page = 1'b0;
        if (page == PG_SCU) begin
            win = WIN_SCU;
        end else if (page == PG_INTC_ALIAS) begin
            win     = WIN_INTC;
            cpu_idx = 4'(req_cpu);
        end else if (page < PG_TMR_ALIAS) begin
            win     = WIN_INTC;
            cpu_idx = page - PG_INTC_BANK0;
        end else if (page == PG_TMR_ALIAS) begin
            win     = WIN_TMR;
            cpu_idx = 4'(req_cpu);
        end else if (page < PG_END) begin
            win     = WIN_TMR;
            cpu_idx = page - PG_TMR_BANK0;
        end else begin
            bad_page = 1'b1;
        end
    end

    // CPU present check against the strapped count
    always_comb begin
        in_range = (5'(cpu_idx) < 5'(cpu_count));
    end

endmodule

// File: rtl/priv_target_sel.sv
// Module: priv_target_sel
// Builds the one-hot downstream selects, the local offset and the interrupt
// number of the selected timer unit. Assumes cpu_idx < MAX_CPU when in range.
module priv_target_sel
    import priv_dec_pkg::*;
#(
    parameter int MAX_CPU = 4,
    parameter int TMR_N   = 2 * MAX_CPU
) (
    input  logic               req_valid,
    input  logic               req_write,
    input  win_e               win,
    input  logic [3:0]         cpu_idx,
    input  logic               in_range,
    input  logic [7:0]         off_lo,
    output logic [MAX_CPU-1:0] intc_sel,
    output logic [TMR_N-1:0]   timer_sel,
    output logic [7:0]         tgt_offset,
    output logic [4:0]         tgt_irq_num,
    output logic               tgt_write,
    output logic               tgt_hit
);

    logic live_intc;
    logic live_tmr;

    // Qualify each region with request valid and CPU presence
    always_comb begin
        live_intc = req_valid && in_range && (win == WIN_INTC);
        live_tmr  = req_valid && in_range && (win == WIN_TMR);
    end

    // One select line per interface and two per timer pair
    for (genvar c = 0; c < MAX_CPU; c++) begin : g_cpu
        assign intc_sel[c]        = live_intc && (cpu_idx == 4'(c));
        assign timer_sel[2*c]     = live_tmr && (cpu_idx == 4'(c)) && !off_lo[5];
        assign timer_sel[2*c + 1] = live_tmr && (cpu_idx == 4'(c)) && off_lo[5];
    end

    // Local offset and interrupt number for the chosen unit
    always_comb begin
        tgt_offset  = '0;
        tgt_irq_num = '0;
        if (live_intc) begin
            tgt_offset = off_lo;
        end else if (live_tmr) begin
            tgt_offset  = {4'b0000, off_lo[3:0]};
            tgt_irq_num = off_lo[5] ? IRQ_WDOG : IRQ_TIMER;
        end
    end

    // Hit and write strobe for downstream
    always_comb begin
        tgt_hit   = (|intc_sel) || (|timer_sel);
        tgt_write = tgt_hit && req_write;
    end

endmodule

// File: rtl/scu_regs.sv
// Module: scu_regs
// Snoop-control register group: a one-bit enable, a configuration word built
// from the CPU count, and two registers that read as zero.
// Assumes 1 <= cpu_count <= MAX_CPU and MAX_CPU <= 4.
module scu_regs
    import priv_dec_pkg::*;
#(
    parameter int MAX_CPU = 4,
    parameter int CPU_W   = 2,
    parameter int CNT_W   = 3,
    parameter int DATA_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc,
    input  logic              write,
    input  logic [7:0]        reg_off,
    input  logic              wbit,
    input  logic [CNT_W-1:0]  cpu_count,
    output logic              ctl,
    output logic              known,
    output logic [DATA_W-1:0] rdata
);

    logic [MAX_CPU-1:0] present;
    logic [CPU_W-1:0]   count_m1;
    logic [DATA_W-1:0]  cfg_word;

    // Recognise the four defined register offsets
    always_comb begin
        case (reg_off)
            SCU_CTL, SCU_CFG, SCU_STAT, SCU_INVAL: known = 1'b1;
            default:                               known = 1'b0;
        endcase
    end

    // Present-CPU mask and count field of the configuration word
    always_comb begin
        for (int i = 0; i < MAX_CPU; i++) begin
            present[i] = (CNT_W'(i) < cpu_count);
        end
        count_m1 = CPU_W'(cpu_count - CNT_W'(1));
        cfg_word = DATA_W'({present, 4'b0000}) | DATA_W'(count_m1);
    end

    // Enable register: only bit 0 of a write to the control offset is kept
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl <= 1'b0;
        end else if (acc && write && (reg_off == SCU_CTL)) begin
            ctl <= wbit;
        end
    end

    // Read multiplexer
    always_comb begin
        case (reg_off)
            SCU_CTL: rdata = DATA_W'(ctl);
            SCU_CFG: rdata = cfg_word;
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/priv_window_decoder.sv
// Module: priv_window_decoder (top)
// Decodes a 12-bit private-window offset into snoop-control, interrupt
// interface and timer-pair targets, and registers a one-cycle response.
// Assumes downstream read data is valid in the request cycle.
module priv_window_decoder
    import priv_dec_pkg::*;
#(
    parameter int MAX_CPU = 4,
    parameter int DATA_W  = 32,
    localparam int CPU_W  = $clog2(MAX_CPU),
    localparam int CNT_W  = $clog2(MAX_CPU + 1),
    localparam int TMR_N  = 2 * MAX_CPU
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [CNT_W-1:0]   cpu_count,
    input  logic               req_valid,
    input  logic               req_write,
    input  logic [CPU_W-1:0]   req_cpu,
    input  logic [11:0]        req_addr,
    input  logic [DATA_W-1:0]  req_wdata,
    input  logic [DATA_W-1:0]  dn_rdata,
    output logic [MAX_CPU-1:0] intc_sel,
    output logic [TMR_N-1:0]   timer_sel,
    output logic [7:0]         tgt_offset,
    output logic [4:0]         tgt_irq_num,
    output logic               tgt_write,
    output logic [DATA_W-1:0]  tgt_wdata,
    output logic               rsp_valid,
    output logic [DATA_W-1:0]  rsp_rdata,
    output logic               rsp_err
);

    win_e              win;
    logic [3:0]        cpu_idx;
    logic              in_range;
    logic              bad_page;
    logic              tgt_hit;
    logic              scu_acc;
    logic              scu_known;
    logic              scu_ctl;
    logic [DATA_W-1:0] scu_rdata;
    logic              req_err;
    logic [DATA_W-1:0] next_rdata;

    priv_addr_decode #(
        .MAX_CPU (MAX_CPU),
        .CPU_W   (CPU_W),
        .CNT_W   (CNT_W)
    ) u_decode (
        .page      (req_addr[11:8]),
        .req_cpu   (req_cpu),
        .cpu_count (cpu_count),
        .win       (win),
        .cpu_idx   (cpu_idx),
        .in_range  (in_range),
        .bad_page  (bad_page)
    );

    priv_target_sel #(
        .MAX_CPU (MAX_CPU),
        .TMR_N   (TMR_N)
    ) u_tsel (
        .req_valid   (req_valid),
        .req_write   (req_write),
        .win         (win),
        .cpu_idx     (cpu_idx),
        .in_range    (in_range),
        .off_lo      (req_addr[7:0]),
        .intc_sel    (intc_sel),
        .timer_sel   (timer_sel),
        .tgt_offset  (tgt_offset),
        .tgt_irq_num (tgt_irq_num),
        .tgt_write   (tgt_write),
        .tgt_hit     (tgt_hit)
    );

    // Snoop-control access qualifier
    assign scu_acc = req_valid && (win == WIN_SCU);

    scu_regs #(
        .MAX_CPU (MAX_CPU),
        .CPU_W   (CPU_W),
        .CNT_W   (CNT_W),
        .DATA_W  (DATA_W)
    ) u_scu (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc       (scu_acc),
        .write     (req_write),
        .reg_off   (req_addr[7:0]),
        .wbit      (req_wdata[0]),
        .cpu_count (cpu_count),
        .ctl       (scu_ctl),
        .known     (scu_known),
        .rdata     (scu_rdata)
    );

    // Write data goes straight to the downstream units
    assign tgt_wdata = req_wdata;

    // Error for unmapped pages and undefined snoop-control offsets
    always_comb begin
        req_err = req_valid && (bad_page || ((win == WIN_SCU) && !scu_known));
    end

    // Read data source for the response
    always_comb begin
        next_rdata = '0;
        if (req_valid && !req_write) begin
            if (scu_acc && scu_known) begin
                next_rdata = scu_rdata;
            end else if (tgt_hit) begin
                next_rdata = dn_rdata;
            end
        end
    end

    // Response register: one cycle after the request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= req_err;
            rsp_rdata <= next_rdata;
        end
    end

endmodule

// File: rtl/priv_window_checker.sv
// Module: priv_window_checker
// Property checks for priv_window_decoder, attached by bind below.
module priv_window_checker #(
    parameter int MAX_CPU = 4,
    parameter int CNT_W   = 3,
    parameter int TMR_N   = 2 * MAX_CPU
) (
    input logic               clk,
    input logic               rst_n,
    input logic [CNT_W-1:0]   cpu_count,
    input logic               req_valid,
    input logic               req_write,
    input logic [11:0]        req_addr,
    input logic               req_wbit,
    input logic [MAX_CPU-1:0] intc_sel,
    input logic [TMR_N-1:0]   timer_sel,
    input logic [4:0]         tgt_irq_num,
    input logic               rsp_valid,
    input logic               rsp_err,
    input logic               scu_ctl
);

    logic       odd_hit;
    logic [3:0] bank_tmr_cpu;
    logic       bank_tmr_hit;

    // Whether a watchdog (odd) select is active
    always_comb begin
        odd_hit = 1'b0;
        for (int i = 1; i < TMR_N; i += 2) begin
            odd_hit = odd_hit | timer_sel[i];
        end
    end

    // Banked timer page and its CPU number, from the address alone
    always_comb begin
        bank_tmr_cpu = req_addr[11:8] - 4'h7;
        bank_tmr_hit = (req_addr >= 12'h700) && (req_addr < 12'hB00);
    end

    assert_ctl_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr == 12'h000)) |=> (scu_ctl == $past(req_wbit)));

    assert_inval_keeps_ctl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && (req_addr == 12'h00C)) |=> $stable(scu_ctl));

    assert_sel_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({intc_sel, timer_sel}));

    assert_irq_number_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (|timer_sel) |-> (tgt_irq_num == (odd_hit ? 5'd30 : 5'd29)));

    assert_absent_cpu_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && bank_tmr_hit && (5'(bank_tmr_cpu) >= 5'(cpu_count))) |-> (timer_sel == '0));

    assert_err_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_addr >= 12'hB00)) |=> rsp_err);

    assert_rsp_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (!rsp_valid && !rsp_err));

endmodule

bind priv_window_decoder priv_window_checker #(
    .MAX_CPU (MAX_CPU),
    .CNT_W   (CNT_W),
    .TMR_N   (TMR_N)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cpu_count   (cpu_count),
    .req_valid   (req_valid),
    .req_write   (req_write),
    .req_addr    (req_addr),
    .req_wbit    (req_wdata[0]),
    .intc_sel    (intc_sel),
    .timer_sel   (timer_sel),
    .tgt_irq_num (tgt_irq_num),
    .rsp_valid   (rsp_valid),
    .rsp_err     (rsp_err),
    .scu_ctl     (scu_ctl)
);

// File: tb/priv_window_decoder_bench.sv
`timescale 1ns/100ps
// Bench: behavioural reference model of the private window, compared on every
// request cycle (combinational outputs) and the following edge (response).
module priv_window_decoder_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cpu_count = 3'd4;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_cpu = 2'd0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic [31:0] dn_rdata = '0;
    logic [3:0]  intc_sel;
    logic [7:0]  timer_sel;
    logic [7:0]  tgt_offset;
    logic [4:0]  tgt_irq_num;
    logic        tgt_write;
    logic [31:0] tgt_wdata;
    logic        rsp_valid;
    logic [31:0] rsp_rdata;
    logic        rsp_err;

    int n_checks = 0;
    int n_fail   = 0;
    int m_ctl    = 0;

    always #2.5 clk = ~clk;

    priv_window_decoder u_priv_window_decoder (
        .clk         (clk),
        .rst_n       (rst_n),
        .cpu_count   (cpu_count),
        .req_valid   (req_valid),
        .req_write   (req_write),
        .req_cpu     (req_cpu),
        .req_addr    (req_addr),
        .req_wdata   (req_wdata),
        .dn_rdata    (dn_rdata),
        .intc_sel    (intc_sel),
        .timer_sel   (timer_sel),
        .tgt_offset  (tgt_offset),
        .tgt_irq_num (tgt_irq_num),
        .tgt_write   (tgt_write),
        .tgt_wdata   (tgt_wdata),
        .rsp_valid   (rsp_valid),
        .rsp_rdata   (rsp_rdata),
        .rsp_err     (rsp_err)
    );

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
        end
    endtask

    // One request cycle: drive, check selects, then check the response
    task automatic step(input bit v, input bit w, input int cpu, input int addr,
                        input int unsigned wd, input string tag);
        int off, page, kind, tcpu, cnt;
        int unsigned e_intc, e_tmr, e_off, e_irq, e_rd;
        bit e_err, hit;
        int nxt_ctl;
        @(negedge clk);
        req_valid = v;
        req_write = w;
        req_cpu   = 2'(cpu);
        req_addr  = 12'(addr);
        req_wdata = wd;
        dn_rdata  = 32'hA500_0000 | 32'(addr);
        off  = addr & 'hFFF;
        page = off >> 8;
        cnt  = int'(cpu_count);
        kind = 0; tcpu = 0; e_err = 0; hit = 0;
        e_intc = 0; e_tmr = 0; e_off = 0; e_irq = 0; e_rd = 0;
        nxt_ctl = m_ctl;
        if (v) begin
            if (page == 0) begin
                if (off == 'h00) begin
                    e_rd = m_ctl;
                    if (w) nxt_ctl = wd & 1;
                end else if (off == 'h04) e_rd = (((1 << cnt) - 1) << 4) | (cnt - 1);
                else if (off == 'h08 || off == 'h0C) e_rd = 0;
                else e_err = 1;
            end else if (page == 1) begin kind = 2; tcpu = cpu; end
            else if (page < 6)     begin kind = 2; tcpu = page - 2; end
            else if (page == 6)    begin kind = 3; tcpu = cpu; end
            else if (page < 11)    begin kind = 3; tcpu = page - 7; end
            else e_err = 1;
            if (kind == 2 && tcpu < cnt) begin
                hit = 1; e_intc = 1 << tcpu; e_off = off & 'hFF;
            end else if (kind == 3 && tcpu < cnt) begin
                hit = 1;
                e_tmr = 1 << (2 * tcpu + ((off >> 5) & 1));
                e_off = off & 'hF;
                e_irq = ((off >> 5) & 1) ? 30 : 29;
            end
            if (hit) e_rd = dn_rdata;
            if (w) e_rd = 0;
        end
        #1;
        chk(tag, "intc_sel", 32'(intc_sel), e_intc);
        chk(tag, "timer_sel", 32'(timer_sel), e_tmr);
        chk(tag, "tgt_offset", 32'(tgt_offset), e_off);
        chk(tag, "tgt_irq_num", 32'(tgt_irq_num), e_irq);
        chk(tag, "tgt_write", 32'(tgt_write), 32'(hit && w));
        chk(tag, "tgt_wdata", tgt_wdata, wd);
        @(posedge clk);
        m_ctl = nxt_ctl;
        #1;
        chk(tag, "rsp_valid", 32'(rsp_valid), 32'(v));
        chk(tag, "rsp_err", 32'(rsp_err), 32'(e_err));
        chk(tag, "rsp_rdata", rsp_rdata, e_rd);
    endtask

    // Hold reset for one edge and check the cleared response (R11)
    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_valid = 1'b0;
        @(posedge clk);
        m_ctl = 0;
        #1;
        chk("R11", "rsp_valid", 32'(rsp_valid), 0);
        chk("R11", "rsp_err", 32'(rsp_err), 0);
        chk("R11", "rsp_rdata", rsp_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        do_reset();
        step(1, 0, 0, 'h000, 0, "R11");            // enable register after reset
        // R1 enable register, only bit 0 kept
        step(1, 1, 0, 'h000, 32'hFFFF_FFFF, "R1");
        step(1, 0, 0, 'h000, 0, "R1");
        step(1, 1, 0, 'h000, 32'h0000_0002, "R1");
        step(1, 0, 0, 'h000, 0, "R1");
        // R2 configuration word with four CPUs
        step(1, 0, 1, 'h004, 0, "R2");
        // R3 zero reads and harmless invalidate write
        step(1, 1, 0, 'h000, 1, "R3");
        step(1, 1, 0, 'h00C, 32'hFFFF_FFFE, "R3");
        step(1, 0, 0, 'h000, 0, "R3");
        step(1, 0, 0, 'h008, 0, "R3");
        step(1, 0, 0, 'h00C, 0, "R3");
        // R9 unknown snoop offset and pages beyond the timers
        step(1, 1, 0, 'h010, 0, "R9");
        step(1, 0, 0, 'h000, 0, "R9");
        step(1, 0, 0, 'h0FC, 0, "R9");
        step(1, 0, 3, 'hB00, 0, "R9");
        step(1, 1, 3, 'hFFF, 32'h1234, "R9");
        // R4 alias interface window for each requesting CPU
        for (int c = 0; c < 4; c++) step(1, 0, c, 'h1A4, 0, "R4");
        step(1, 1, 2, 'h1FF, 32'hCAFE_0001, "R4");
        // R5 banked interface windows
        step(1, 0, 3, 'h200, 0, "R5");
        step(1, 0, 0, 'h3FC, 0, "R5");
        step(1, 1, 1, 'h5FF, 32'h55, "R5");
        // R6 alias timer pair, timer then watchdog
        step(1, 0, 2, 'h608, 0, "R6");
        step(1, 0, 2, 'h628, 0, "R6");
        step(1, 1, 0, 'h6FF, 32'h77, "R6");
        // R7 banked timer pairs
        step(1, 0, 0, 'h734, 0, "R7");
        step(1, 0, 0, 'h9E1, 0, "R7");
        step(1, 1, 1, 'hAC3, 32'h99, "R7");
        // R10 idle cycle between requests
        step(0, 0, 0, 'h100, 0, "R10");
        // R8 absent CPUs with two present
        cpu_count = 3'd2;
        step(1, 0, 0, 'h004, 0, "R2");
        step(1, 0, 0, 'h400, 0, "R8");
        step(1, 1, 0, 'h500, 32'h1, "R8");
        step(1, 0, 0, 'h820, 0, "R8");
        step(1, 0, 0, 'h900, 0, "R8");
        step(1, 0, 3, 'h104, 0, "R8");
        step(1, 0, 2, 'h628, 0, "R8");
        // one CPU
        cpu_count = 3'd1;
        step(1, 0, 0, 'h004, 0, "R2");
        step(1, 0, 0, 'h800, 0, "R8");
        step(1, 0, 0, 'h700, 0, "R7");
        // R11 reset clears the enable register mid-run
        step(1, 1, 0, 'h000, 1, "R11");
        do_reset();
        step(1, 0, 0, 'h000, 0, "R11");
        step(0, 0, 0, 'h000, 0, "R10");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule